// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that were hoisted above older stores whose addresses were not known to be disjoint. When such a hoisted load issues, it registers its destination register number, its byte address and its access width. Every store that later executes presents its own address and width, and any recorded load whose byte range overlaps the store's range is dropped. At the load's original program position, a check names the destination register. The block answers one cycle later with pass (the load's value is still good) or fail (recovery code must redo the load and its dependents).

Because a missing record always produces a fail, losing an entry costs only time and never gives a wrong result. Evicting the oldest record when the table is full, replacing a record when its register is reused, and a flush that empties the whole table are therefore all safe. All three request ports use a valid/ready pair. Ready is always high, so every request is taken in the cycle it is presented.

Top module: `ldspec_table`

## Requirements
- R1: After reset, and in every cycle after a cycle with `flush` high, the table holds no entries, so any check fails.
- R2: An accepted insert records register, address and size. A check of that register in the next cycle passes when no overlapping store or flush comes in between.
- R3: All ready outputs are high. `chk_resp_valid` is high exactly one cycle after each cycle with `chk_valid`, and carries the result in `chk_pass`. A passing check leaves its entry in place, so a repeated check passes again.
- R4: A store covers bytes [addr, addr + 2^size), where size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A store invalidates every entry whose byte range, computed the same way, shares at least one byte with it.
- R5: A store whose range only touches an entry's range at an edge, without sharing a byte, leaves the entry valid.
- R6: An insert to a register that already has an entry overwrites that entry, so each register has at most one entry. A later store to the old address has no effect on the entry.
- R7: When all 16 entries are valid, an insert for a new register evicts the entry inserted least recently (a re-insert counts as a new insertion). A check of the evicted register fails. The other entries stay.
- R8: When a store and a check in the same cycle hit the same entry, the invalidation is applied first and the check fails.
- R9: A check in the same cycle as `flush` fails, and an insert in that cycle is dropped.
- R10: A store in the same cycle as an insert invalidates only older entries. The newly inserted entry survives even when its range overlaps the store.
- R11: A check in the same cycle as an insert for the same register sees the table as it was before that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear every entry |
| ins_valid | input | 1 | Advanced-load insert request |
| ins_ready | output | 1 | Insert accepted (always 1) |
| ins_reg | input | REG_W | Destination register of the load |
| ins_addr | input | ADDR_W | Byte address of the load |
| ins_size | input | 2 | Log2 of access bytes |
| snoop_valid | input | 1 | Store address presented |
| snoop_ready | output | 1 | Store accepted (always 1) |
| snoop_addr | input | ADDR_W | Byte address of the store |
| snoop_size | input | 2 | Log2 of store bytes |
| chk_valid | input | 1 | Check request |
| chk_ready | output | 1 | Check accepted (always 1) |
| chk_reg | input | REG_W | Register being checked |
| chk_resp_valid | output | 1 | Check result valid, one cycle after request |
| chk_pass | output | 1 | 1 = entry present, 0 = recovery needed |

## Verification
The bench probes the edges of the byte-overlap test: stores that end exactly where an entry starts, or start exactly where it ends, must leave the entry alone. A design that used inclusive range ends would wrongly force recovery. The bench also checks same-cycle orderings (store against check, flush against check and insert, insert against store, insert against check), where a wrong priority shows up as a false pass, a lost entry or a check that already sees the new insert. Finally, it fills the table, re-inserts one register and overflows the table twice. An eviction policy that ignores re-insertion order, or that replaces a random slot, would lose the wrong register.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  localparam int unsigned SIZE_W = 2;

  // Number of bytes covered by a size code.
  function automatic logic [64:0] span_bytes(input logic [SIZE_W-1:0] sz);
    return 65'd1 << sz;
  endfunction

  // Half-open byte ranges [a, a+len) and [b, b+len) share a byte.
  function automatic logic span_overlap(input logic [63:0] a, input logic [SIZE_W-1:0] asz,
                                        input logic [63:0] b, input logic [SIZE_W-1:0] bsz);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a} + span_bytes(asz);
    b_end = {1'b0, b} + span_bytes(bsz);
    return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
  endfunction

endpackage

// File: rtl/ldspec_entry.sv
module ldspec_entry
  import ldspec_pkg::*;
#(
  parameter int unsigned REG_W  = 7,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SIZE_W-1:0] snp_size,
  output logic              ent_valid,
  output logic [REG_W-1:0]  ent_reg,
  output logic              snp_kill
);

  logic [ADDR_W-1:0] ent_addr;
  logic [SIZE_W-1:0] ent_size;

  // Store hit on this entry in the current cycle.
  assign snp_kill = ent_valid && snp_valid &&
                    span_overlap(64'(ent_addr), ent_size, 64'(snp_addr), snp_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_reg   <= '0;
      ent_addr  <= '0;
      ent_size  <= '0;
    end else begin
      if (flush)         ent_valid <= 1'b0;
      else if (wr_en)    ent_valid <= 1'b1;   // new insert survives a same-cycle store
      else if (snp_kill) ent_valid <= 1'b0;
      if (wr_en && !flush) begin
        ent_reg  <= wr_reg;
        ent_addr <= wr_addr;
        ent_size <= wr_size;
      end
    end
  end

endmodule

// File: rtl/ldspec_age.sv
module ldspec_age #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [DEPTH-1:0] ins_slot,
  output logic [DEPTH-1:0] oldest
);

  // older[i][j] = slot i was written before slot j.
  logic [DEPTH-1:0][DEPTH-1:0] older;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else if (ins_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (ins_slot[i])                older[i][j] <= 1'b0;
          else if (ins_slot[j] && i != j) older[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      oldest[i] = &(older[i] | (DEPTH'(1) << i));
    end
  end

endmodule

// File: rtl/ldspec_table.sv
module ldspec_table
  import ldspec_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned REG_W  = 7,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              snoop_valid,
  output logic              snoop_ready,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [1:0]        snoop_size,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_resp_valid,
  output logic              chk_pass
);

  logic [DEPTH-1:0] ent_valid;
  logic [REG_W-1:0] ent_reg [DEPTH];
  logic [DEPTH-1:0] snp_kill;
  logic [DEPTH-1:0] same_reg_hit;
  logic [DEPTH-1:0] free_vec;
  logic [DEPTH-1:0] free_low;
  logic [DEPTH-1:0] oldest;
  logic [DEPTH-1:0] victim;
  logic [DEPTH-1:0] chk_hit_vec;
  logic             chk_killed;
  logic             ins_fire;

  assign ins_ready   = 1'b1;
  assign snoop_ready = 1'b1;
  assign chk_ready   = 1'b1;
  assign ins_fire    = ins_valid && !flush;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ldspec_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (ins_fire && victim[g]),
      .wr_reg    (ins_reg),
      .wr_addr   (ins_addr),
      .wr_size   (ins_size),
      .snp_valid (snoop_valid),
      .snp_addr  (snoop_addr),
      .snp_size  (snoop_size),
      .ent_valid (ent_valid[g]),
      .ent_reg   (ent_reg[g]),
      .snp_kill  (snp_kill[g])
    );
    assign same_reg_hit[g] = ent_valid[g] && (ent_reg[g] == ins_reg);
    assign chk_hit_vec[g]  = ent_valid[g] && (ent_reg[g] == chk_reg);
  end

  ldspec_age #(.DEPTH(DEPTH)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ins_fire),
    .ins_slot (victim),
    .oldest   (oldest)
  );

  // Slot choice: same register first, then lowest free slot, then oldest.
  assign free_vec = ~ent_valid;
  assign free_low = free_vec & (~free_vec + DEPTH'(1));

  always_comb begin
    if (|same_reg_hit)  victim = same_reg_hit;
    else if (|free_vec) victim = free_low;
    else                victim = oldest;
  end

  assign chk_killed = |(chk_hit_vec & snp_kill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_resp_valid <= 1'b0;
      chk_pass       <= 1'b0;
    end else begin
      chk_resp_valid <= chk_valid;
      chk_pass       <= chk_valid && !flush && |(chk_hit_vec & ~snp_kill);
    end
  end

endmodule

// File: rtl/ldspec_table_chk.sv
module ldspec_table_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             ins_valid,
  input logic [REG_W-1:0] ins_reg,
  input logic             snoop_valid,
  input logic             chk_valid,
  input logic [REG_W-1:0] chk_reg,
  input logic             chk_resp_valid,
  input logic             chk_pass,
  input logic [DEPTH-1:0] ent_valid,
  input logic [DEPTH-1:0] chk_hit_vec,
  input logic             chk_killed
);

  assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_resp_valid);

  assert_no_stray_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_resp_valid);

  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0));

  assert_flush_fails_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && chk_valid) |=> !chk_pass);

  assert_kill_before_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_killed) |=> !chk_pass);

  assert_one_entry_per_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_hit_vec));

  assert_full_stays_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid && ins_valid && !flush && !snoop_valid) |=> &ent_valid);

  assert_fresh_insert_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ins_valid && !flush) && chk_valid && chk_reg == $past(ins_reg) &&
     !snoop_valid && !flush) |=> chk_pass);

endmodule

bind ldspec_table ldspec_table_chk #(.DEPTH(DEPTH), .REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush          (flush),
  .ins_valid      (ins_valid),
  .ins_reg        (ins_reg),
  .snoop_valid    (snoop_valid),
  .chk_valid      (chk_valid),
  .chk_reg        (chk_reg),
  .chk_resp_valid (chk_resp_valid),
  .chk_pass       (chk_pass),
  .ent_valid      (ent_valid),
  .chk_hit_vec    (chk_hit_vec),
  .chk_killed     (chk_killed)
);

// File: tb/ldspec_table_test.sv
module ldspec_table_test;

  localparam int REG_W  = 7;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              ins_valid = 1'b0;
  logic              ins_ready;
  logic [REG_W-1:0]  ins_reg = '0;
  logic [ADDR_W-1:0] ins_addr = '0;
  logic [1:0]        ins_size = '0;
  logic              snoop_valid = 1'b0;
  logic              snoop_ready;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic [1:0]        snoop_size = '0;
  logic              chk_valid = 1'b0;
  logic              chk_ready;
  logic [REG_W-1:0]  chk_reg = '0;
  logic              chk_resp_valid;
  logic              chk_pass;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ldspec_table #(.DEPTH(16), .REG_W(REG_W), .ADDR_W(ADDR_W)) uut (.*);

  task automatic check_bit(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a response appears.
  always @(negedge clk) begin
    if (rst_n && chk_resp_valid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R3: unexpected response got 1 expected 0");
      end else begin
        check_bit(tag_q.pop_front(), chk_pass, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    ins_valid = 0; snoop_valid = 0; chk_valid = 0; flush = 0;
  endtask

  task automatic put_ins(int r, int a, int sz);
    ins_valid = 1; ins_reg = REG_W'(r); ins_addr = ADDR_W'(a); ins_size = 2'(sz);
  endtask

  task automatic put_snoop(int a, int sz);
    snoop_valid = 1; snoop_addr = ADDR_W'(a); snoop_size = 2'(sz);
  endtask

  task automatic put_chk(int r, logic exp, string tag);
    chk_valid = 1; chk_reg = REG_W'(r);
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_bit("R3 ready outputs", ins_ready & snoop_ready & chk_ready, 1'b1);
    check_bit("R3 no response after reset", chk_resp_valid, 1'b0);
    put_chk(5, 0, "R1 empty after reset"); tick();

    // R2/R3: insert then repeated checks
    put_ins(5, 'h100, 2); tick();
    put_chk(5, 1, "R2 check after insert"); tick();
    put_chk(5, 1, "R3 repeat check still passes"); tick();

    // R11: check in same cycle as insert sees old table
    put_ins(6, 'h200, 3); put_chk(6, 0, "R11 same-cycle insert not visible"); tick();
    put_chk(6, 1, "R11 visible next cycle"); tick();

    // R5: abutting stores keep the entry [0x100,0x104)
    put_snoop('h104, 2); tick();
    put_snoop('h0FC, 2); tick();
    put_chk(5, 1, "R5 abutting stores ignored"); tick();

    // R4: overlapping stores kill
    put_snoop('h103, 0); tick();
    put_chk(5, 0, "R4 one-byte overlap at top end"); tick();
    put_snoop('h1FC, 3); tick();
    put_chk(6, 0, "R4 eight-byte store overlaps start"); tick();

    // R6: re-insert replaces the address
    put_ins(7, 'h300, 2); tick();
    put_ins(7, 'h400, 2); tick();
    put_snoop('h300, 3); tick();
    put_chk(7, 1, "R6 old address no longer tracked"); tick();
    put_snoop('h402, 0); tick();
    put_chk(7, 0, "R6 new address tracked"); tick();

    // R8: store and check same cycle
    put_ins(8, 'h500, 1); tick();
    put_snoop('h501, 0); put_chk(8, 0, "R8 invalidation before check"); tick();
    put_chk(8, 0, "R8 entry stays gone"); tick();

    // R10: insert survives same-cycle store, older entry dies
    put_ins(10, 'h600, 2); tick();
    put_ins(9, 'h600, 2); put_snoop('h600, 2); tick();
    put_chk(9, 1, "R10 new entry survives store"); tick();
    put_chk(10, 0, "R10 older entry invalidated"); tick();

    // R9: flush with check and insert
    put_ins(11, 'h700, 0); tick();
    put_chk(9, 1, "R9 entry before flush"); tick();
    flush = 1; put_chk(11, 0, "R9 check during flush"); put_ins(12, 'h800, 0); tick();
    put_chk(11, 0, "R1 empty after flush"); tick();
    put_chk(12, 0, "R9 insert during flush dropped"); tick();

    // R7: fill, re-insert oldest, overflow twice
    for (int i = 0; i < 16; i++) begin
      put_ins(20 + i, 'h1000 + i * 16, 0); tick();
    end
    put_ins(20, 'h2000, 0); tick();
    put_ins(40, 'h3000, 0); tick();
    put_chk(21, 0, "R7 oldest evicted"); tick();
    put_chk(20, 1, "R7 re-inserted entry kept"); tick();
    put_chk(22, 1, "R7 next oldest still present"); tick();
    put_chk(40, 1, "R7 new entry present"); tick();
    put_chk(35, 1, "R7 youngest fill entry present"); tick();
    put_ins(41, 'h3100, 0); tick();
    put_chk(22, 0, "R7 second eviction"); tick();
    put_chk(41, 1, "R7 second new entry present"); tick();

    flush = 1; tick();
    put_chk(40, 0, "R1 flush clears full table"); tick();

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R3: missing responses got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule